// File: doc/BRIEF.md
# Dual-Channel Reloadable Down-Counter Timer

This peripheral holds a parameterised number of independent timer channels behind a simple word-wide register port. Each channel counts down by one on every pulse of a tick line that software picks through a four-bit select code. The live count and the value it reloads from are kept in separate registers: software writes a target count and reads back the live count. When an armed channel is already at zero and a tick arrives, it raises a sticky pending flag. The channel's interrupt output is that flag gated by an enable bit.

Two control bits decide how a channel behaves. With the immediate-load bit set, a write to the target register is copied into the live counter on the same clock edge and arms the channel, which suits one-shot event timing. With the auto-restart bit set, a channel that expires loads the target again and keeps counting, which gives a free-running periodic source. Software acknowledges an event by writing a one to the pending bit through a clear-alias address.

Each control register also has a set alias and a clear alias. These let software change single bits without a read-modify-write sequence. The tick inputs are single-cycle enable pulses from an external prescaler. No clock generation takes place inside the block.

Top module: `cdown_timer`

## Requirements
- R1: With no load write in a cycle, the live count of a nonzero channel drops by exactly one on each cycle in which its selected tick line is high. On every other cycle it holds its value.
- R2: Control bits [3:0] hold the tick select code, and code k picks tick line k. Code 0xB picks line 11, which by convention carries the 32 kHz crystal tick. A code that names no existing tick line (with the default 12 lines, 0xC through 0xF) stops the channel. Pulses on lines that are not selected have no effect on the count.
- R3: Control bit 7 is the immediate-load bit. When it is 1, a write to the target register also loads the live count on the same edge and arms the channel. When it is 0, the write changes only the target register.
- R4: An armed channel at zero that receives a tick sets control bit 15, the pending flag. With control bit 6 (auto-restart) at 0, the channel then stays at zero, is disarmed, and raises no further flag until it is armed again. A channel that is not armed never sets the flag.
- R5: With control bit 6 at 1, a tick at zero loads the target value into the live count and arms the channel. This happens even when the channel was not armed, and it gives periodic expiries.
- R6: The interrupt output irq_o[n] is high exactly when control bit 14 (enable) and control bit 15 (pending) of channel n are both 1.
- R7: The registers of channel n sit at byte addresses based on n*0x40. The control word is at 0x20+n*0x40 and takes plain writes. Its set alias is 4 bytes above it and ORs written ones into the control word. Its clear alias is 8 bytes above it and clears the bits written as ones. The live count is at 0x30+n*0x40 and is read-only. The target value is at 0x40+n*0x40 and can be read and written. Control bits other than 0-3, 6, 7, 14 and 15 read 0, as does every other address, including the two aliases.
- R8: A target write with immediate load in the same cycle as a tick overrides the tick: the count takes the written value. A pending flag set by an expiry in the same cycle as a clear-alias write stays set.
- R9: A synchronous reset clears every control word, live count, target value, pending flag and arm state, so after reset no channel expires until it is armed again.
- R10: The count is 32 bits wide by default. A load of 0xFFFFFFFF is held in full and decrements to 0xFFFFFFFE on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | NUM_TICK | Single-cycle tick enables from the prescaler, one per line |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| irq_o | output | NUM_CH | Per-channel interrupt (enable AND pending) |

## Verification
A wrong count value shows up when the live-count register is read one cycle after the tick that caused it. A wrong arm state only shows up later, at the next expiry: it can produce a missing or extra pending flag, or a reload that never happens. The stimulus therefore runs each channel through expiry in both restart modes and reads the control word and irq_o right after that expiry. The two same-cycle collisions are driven directly, because an error in priority leaves no trace in any other pattern.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

   localparam int BUS_W      = 32;
   localparam int SEL_W      = 4;

   // Control word bit positions
   localparam int RESTART_B  = 6;
   localparam int IMMLOAD_B  = 7;
   localparam int IRQEN_B    = 14;
   localparam int PEND_B     = 15;

   // Address layout per channel
   localparam int CH_STRIDE  = 'h40;
   localparam int CTL_OFS    = 'h20;
   localparam int SET_OFS    = 'h24;
   localparam int CLR_OFS    = 'h28;
   localparam int LIVE_OFS   = 'h30;
   localparam int TGT_OFS    = 'h40;

   typedef struct packed {
      logic             pend;
      logic             irq_en;
      logic             imm_load;
      logic             restart;
      logic [SEL_W-1:0] sel;
   } ctl_t;

   function automatic logic [BUS_W-1:0] ctl_pack(ctl_t c);
      logic [BUS_W-1:0] w;
      w            = '0;
      w[SEL_W-1:0] = c.sel;
      w[RESTART_B] = c.restart;
      w[IMMLOAD_B] = c.imm_load;
      w[IRQEN_B]   = c.irq_en;
      w[PEND_B]    = c.pend;
      return w;
   endfunction

   function automatic ctl_t ctl_unpack(logic [BUS_W-1:0] w);
      ctl_t c;
      c.sel      = w[SEL_W-1:0];
      c.restart  = w[RESTART_B];
      c.imm_load = w[IMMLOAD_B];
      c.irq_en   = w[IRQEN_B];
      c.pend     = w[PEND_B];
      return c;
   endfunction

endpackage

// File: rtl/cdt_tick_mux.sv
module cdt_tick_mux
   import cdt_pkg::*;
#(
   parameter int NUM_TICK = 12
) (
   input  logic [NUM_TICK-1:0] tick_i,
   input  logic [SEL_W-1:0]    sel,
   output logic                tick_o
);

   localparam int NUM_CODES = 1 << SEL_W;

   initial begin
      tick_range_chk: assert (NUM_TICK >= 1 && NUM_TICK <= NUM_CODES)
         else $error("NUM_TICK must be 1..%0d", NUM_CODES);
   end

   generate
      if (NUM_TICK == 1) begin : g_single
         assign tick_o = tick_i[0] & (sel == '0);
      end else begin : g_multi
         always_comb begin
            tick_o = 1'b0;
            for (int i = 0; i < NUM_TICK; i++) begin
               if (sel == SEL_W'(i)) tick_o = tick_i[i];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cdt_channel.sv
module cdt_channel
   import cdt_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             ctl_wr,
   input  logic             ctl_set,
   input  logic             ctl_clr,
   input  logic             tgt_wr,
   input  logic [BUS_W-1:0] wdata,
   output ctl_t             ctl_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] tgt_q,
   output logic             irq
);

   initial begin
      cnt_width_chk: assert (CNT_W >= 1 && CNT_W <= BUS_W)
         else $error("CNT_W must be 1..%0d", BUS_W);
   end

   ctl_t             wr_f;
   ctl_t             ctl_d;
   logic             armed_q;
   logic             load_now;
   logic             at_zero;
   logic             expire;

   assign wr_f     = ctl_unpack(wdata);
   assign load_now = tgt_wr & ctl_q.imm_load;
   assign at_zero  = (cnt_q == '0);
   assign expire   = tick & at_zero & armed_q & ~load_now;

   always_comb begin
      ctl_d = ctl_q;
      if (ctl_wr)  ctl_d = wr_f;
      if (ctl_set) ctl_d = ctl_t'(ctl_d | wr_f);
      if (ctl_clr) ctl_d = ctl_t'(ctl_d & ~wr_f);
      if (expire)  ctl_d.pend = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_q   <= '0;
         cnt_q   <= '0;
         tgt_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         ctl_q <= ctl_d;
         if (tgt_wr) tgt_q <= wdata[CNT_W-1:0];
         if (load_now) begin
            cnt_q   <= wdata[CNT_W-1:0];
            armed_q <= 1'b1;
         end else if (tick) begin
            if (at_zero) begin
               if (ctl_q.restart) begin
                  cnt_q   <= tgt_q;
                  armed_q <= 1'b1;
               end else begin
                  armed_q <= 1'b0;
               end
            end else begin
               cnt_q <= cnt_q - CNT_W'(1);
            end
         end
      end
   end

   assign irq = ctl_q.irq_en & ctl_q.pend;

   // R1
   dec_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
      tick && !at_zero && !load_now |=> cnt_q == $past(cnt_q) - CNT_W'(1));

   // R1
   hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !tick && !load_now |=> $stable(cnt_q));

   // R3
   imm_load_chk: assert property (@(posedge clk) disable iff (rst)
      tgt_wr && ctl_q.imm_load |=> cnt_q == $past(wdata[CNT_W-1:0]));

   // R4
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
      tick && at_zero && !ctl_q.restart && !load_now |=> cnt_q == '0 && !armed_q);

   // R5
   restart_load_chk: assert property (@(posedge clk) disable iff (rst)
      tick && at_zero && ctl_q.restart && !load_now |=> cnt_q == $past(tgt_q) && armed_q);

   // R8
   pend_wins_chk: assert property (@(posedge clk) disable iff (rst)
      tick && at_zero && armed_q && !load_now |=> ctl_q.pend);

   // R4
   no_flag_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
      !armed_q && !ctl_wr && !ctl_set && !ctl_q.pend |=> !ctl_q.pend);

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> cnt_q == '0 && tgt_q == '0 && ctl_q == '0 && !armed_q);

endmodule

// File: rtl/cdown_timer.sv
module cdown_timer
   import cdt_pkg::*;
#(
   parameter int NUM_CH   = 2,
   parameter int CNT_W    = 32,
   parameter int NUM_TICK = 12,
   parameter int ADDR_W   = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_TICK-1:0] tick_i,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [BUS_W-1:0]    wdata,
   output logic [BUS_W-1:0]    rdata,
   output logic [NUM_CH-1:0]   irq_o
);

   localparam longint TOP_ADDR = longint'(TGT_OFS) + longint'(NUM_CH - 1) * longint'(CH_STRIDE);

   initial begin
      num_ch_chk: assert (NUM_CH >= 1)
         else $error("NUM_CH must be at least 1");
      addr_fit_chk: assert (ADDR_W <= 31 && TOP_ADDR < (longint'(1) << ADDR_W))
         else $error("ADDR_W too small for %0d channels", NUM_CH);
   end

   logic [BUS_W-1:0] rd_ch [NUM_CH];

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(CTL_OFS  + n * CH_STRIDE);
      localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(SET_OFS  + n * CH_STRIDE);
      localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_OFS  + n * CH_STRIDE);
      localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(LIVE_OFS + n * CH_STRIDE);
      localparam logic [ADDR_W-1:0] A_TGT  = ADDR_W'(TGT_OFS  + n * CH_STRIDE);

      ctl_t             ctl;
      logic [CNT_W-1:0] cnt;
      logic [CNT_W-1:0] tgt;
      logic [BUS_W-1:0] cnt_ext;
      logic [BUS_W-1:0] tgt_ext;
      logic             tick_sel;

      cdt_tick_mux #(
         .NUM_TICK (NUM_TICK)
      ) u_tick (
         .tick_i (tick_i),
         .sel    (ctl.sel),
         .tick_o (tick_sel)
      );

      cdt_channel #(
         .CNT_W (CNT_W)
      ) u_chan (
         .clk     (clk),
         .rst     (rst),
         .tick    (tick_sel),
         .ctl_wr  (wr_en && addr == A_CTL),
         .ctl_set (wr_en && addr == A_SET),
         .ctl_clr (wr_en && addr == A_CLR),
         .tgt_wr  (wr_en && addr == A_TGT),
         .wdata   (wdata),
         .ctl_q   (ctl),
         .cnt_q   (cnt),
         .tgt_q   (tgt),
         .irq     (irq_o[n])
      );

      if (CNT_W == BUS_W) begin : g_full
         assign cnt_ext = cnt;
         assign tgt_ext = tgt;
      end else begin : g_pad
         assign cnt_ext = {{(BUS_W - CNT_W){1'b0}}, cnt};
         assign tgt_ext = {{(BUS_W - CNT_W){1'b0}}, tgt};
      end

      always_comb begin
         if (addr == A_CTL)       rd_ch[n] = ctl_pack(ctl);
         else if (addr == A_LIVE) rd_ch[n] = cnt_ext;
         else if (addr == A_TGT)  rd_ch[n] = tgt_ext;
         else                     rd_ch[n] = '0;
      end

      // R6
      irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
         irq_o[n] |-> ctl_pack(ctl)[PEND_B] && ctl_pack(ctl)[IRQEN_B]);
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CH; i++) rdata = rdata | rd_ch[i];
   end

endmodule

// File: tb/cdown_timer_tb.sv
module cdown_timer_tb;

   localparam int NT = 12;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [NT-1:0] tick_i = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [1:0]  irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   cdown_timer #(.NUM_CH(2), .CNT_W(32), .NUM_TICK(NT), .ADDR_W(8)) u_dut (
      .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
   );

   localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_IRQ = 2'd3;

   typedef struct packed {
      logic [1:0]  op;
      logic [7:0]  a;
      logic [31:0] d;
      logic [31:0] e;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 65;
   localparam vec_t VEC [NV] = '{
      '{OP_WR,  8'h20, 32'h408B, 32'h0, 8'd7},
      '{OP_RD,  8'h20, 32'h0, 32'h408B, 8'd7},      // R7 readback
      '{OP_WR,  8'h40, 32'h3, 32'h0, 8'd3},
      '{OP_RD,  8'h30, 32'h0, 32'h3, 8'd3},         // R3 immediate load
      '{OP_RD,  8'h40, 32'h0, 32'h3, 8'd7},
      '{OP_TK,  8'd5,  32'd2, 32'h0, 8'd2},
      '{OP_RD,  8'h30, 32'h0, 32'h3, 8'd2},         // R2 other line ignored
      '{OP_TK,  8'd11, 32'd1, 32'h0, 8'd1},
      '{OP_RD,  8'h30, 32'h0, 32'h2, 8'd1},         // R1 decrement
      '{OP_TK,  8'd11, 32'd2, 32'h0, 8'd1},
      '{OP_RD,  8'h30, 32'h0, 32'h0, 8'd1},
      '{OP_IRQ, 8'h0,  32'h0, 32'h0, 8'd6},
      '{OP_TK,  8'd11, 32'd1, 32'h0, 8'd4},
      '{OP_RD,  8'h20, 32'h0, 32'hC08B, 8'd4},      // R4 flag raised
      '{OP_IRQ, 8'h0,  32'h0, 32'h1, 8'd6},         // R6
      '{OP_WR,  8'h28, 32'h8000, 32'h0, 8'd7},
      '{OP_RD,  8'h20, 32'h0, 32'h408B, 8'd7},
      '{OP_IRQ, 8'h0,  32'h0, 32'h0, 8'd6},
      '{OP_TK,  8'd11, 32'd3, 32'h0, 8'd4},
      '{OP_RD,  8'h20, 32'h0, 32'h408B, 8'd4},      // R4 no repeat
      '{OP_RD,  8'h30, 32'h0, 32'h0, 8'd4},
      '{OP_WR,  8'h28, 32'h4000, 32'h0, 8'd7},
      '{OP_WR,  8'h24, 32'h8000, 32'h0, 8'd7},
      '{OP_RD,  8'h20, 32'h0, 32'h808B, 8'd7},
      '{OP_IRQ, 8'h0,  32'h0, 32'h0, 8'd6},         // R6 gated off
      '{OP_WR,  8'h24, 32'h4000, 32'h0, 8'd7},
      '{OP_IRQ, 8'h0,  32'h0, 32'h1, 8'd6},
      '{OP_WR,  8'h28, 32'h8000, 32'h0, 8'd7},
      '{OP_IRQ, 8'h0,  32'h0, 32'h0, 8'd6},
      '{OP_WR,  8'h60, 32'h4043, 32'h0, 8'd5},
      '{OP_WR,  8'h80, 32'h2, 32'h0, 8'd3},
      '{OP_RD,  8'h70, 32'h0, 32'h0, 8'd3},         // R3 no load
      '{OP_TK,  8'd3,  32'd1, 32'h0, 8'd5},
      '{OP_RD,  8'h70, 32'h0, 32'h2, 8'd5},         // R5 load from zero
      '{OP_RD,  8'h60, 32'h0, 32'h4043, 8'd5},
      '{OP_TK,  8'd3,  32'd2, 32'h0, 8'd5},
      '{OP_RD,  8'h70, 32'h0, 32'h0, 8'd5},
      '{OP_TK,  8'd3,  32'd1, 32'h0, 8'd5},
      '{OP_RD,  8'h70, 32'h0, 32'h2, 8'd5},         // R5 reload
      '{OP_RD,  8'h60, 32'h0, 32'hC043, 8'd5},
      '{OP_IRQ, 8'h0,  32'h0, 32'h2, 8'd6},
      '{OP_RD,  8'h30, 32'h0, 32'h0, 8'd1},
      '{OP_WR,  8'h80, 32'h5, 32'h0, 8'd3},
      '{OP_RD,  8'h70, 32'h0, 32'h2, 8'd3},
      '{OP_TK,  8'd3,  32'd3, 32'h0, 8'd5},
      '{OP_RD,  8'h70, 32'h0, 32'h5, 8'd5},         // R5 new target
      '{OP_WR,  8'h68, 32'h8000, 32'h0, 8'd7},
      '{OP_IRQ, 8'h0,  32'h0, 32'h0, 8'd6},
      '{OP_RD,  8'h00, 32'h0, 32'h0, 8'd7},         // R7 unmapped
      '{OP_RD,  8'h2C, 32'h0, 32'h0, 8'd7},
      '{OP_WR,  8'h70, 32'h55, 32'h0, 8'd7},
      '{OP_RD,  8'h70, 32'h0, 32'h5, 8'd7},         // R7 live read-only
      '{OP_WR,  8'h40, 32'hFFFFFFFF, 32'h0, 8'd10},
      '{OP_RD,  8'h30, 32'h0, 32'hFFFFFFFF, 8'd10}, // R10
      '{OP_TK,  8'd11, 32'd1, 32'h0, 8'd10},
      '{OP_RD,  8'h30, 32'h0, 32'hFFFFFFFE, 8'd10},
      '{OP_WR,  8'h60, 32'h404C, 32'h0, 8'd2},
      '{OP_TK,  8'd3,  32'd2, 32'h0, 8'd2},
      '{OP_RD,  8'h70, 32'h0, 32'h5, 8'd2},         // R2 code with no line
      '{OP_WR,  8'h68, 32'hFFFFFFFF, 32'h0, 8'd7},
      '{OP_RD,  8'h60, 32'h0, 32'h0, 8'd7},
      '{OP_WR,  8'h64, 32'hFFFFFFFF, 32'h0, 8'd7},
      '{OP_RD,  8'h60, 32'h0, 32'hC0CF, 8'd7},      // R7 unused bits zero
      '{OP_IRQ, 8'h0,  32'h0, 32'h2, 8'd6},
      '{OP_WR,  8'h68, 32'hFFFFFFFF, 32'h0, 8'd7}
   };

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rd(input logic [7:0] a, input logic [31:0] e, input int req);
      @(negedge clk);
      addr = a;
      #1 check(req, rdata, e);
   endtask

   task automatic do_irq(input logic [31:0] e, input int req);
      @(negedge clk);
      #1 check(req, {30'b0, irq_o}, e);
   endtask

   task automatic do_tick(input int line, input int cnt);
      for (int k = 0; k < cnt; k++) begin
         @(negedge clk);
         tick_i[line] = 1'b1;
         @(negedge clk);
         tick_i = '0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R9 reset state
      do_rd(8'h20, 32'h0, 9);
      do_rd(8'h30, 32'h0, 9);
      do_irq(32'h0, 9);

      for (int v = 0; v < NV; v++) begin
         case (VEC[v].op)
            OP_WR:  do_wr(VEC[v].a, VEC[v].d);
            OP_RD:  do_rd(VEC[v].a, VEC[v].e, int'(VEC[v].req));
            OP_TK:  do_tick(int'(VEC[v].a), int'(VEC[v].d));
            default: do_irq(VEC[v].e, int'(VEC[v].req));
         endcase
      end

      // R8 load write beats a same-cycle tick
      @(negedge clk);
      wr_en = 1'b1; addr = 8'h40; wdata = 32'h7; tick_i[11] = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; tick_i = '0;
      do_rd(8'h30, 32'h7, 8);

      // R8 expiry beats a same-cycle clear-alias write
      do_tick(11, 7);
      do_rd(8'h30, 32'h0, 8);
      @(negedge clk);
      wr_en = 1'b1; addr = 8'h28; wdata = 32'h8000; tick_i[11] = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; tick_i = '0;
      do_rd(8'h20, 32'hC08B, 8);
      do_irq(32'h1, 8);

      // R9 reset mid-run
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      do_rd(8'h20, 32'h0, 9);
      do_rd(8'h30, 32'h0, 9);
      do_rd(8'h40, 32'h0, 9);
      do_rd(8'h60, 32'h0, 9);
      do_rd(8'h70, 32'h0, 9);
      do_rd(8'h80, 32'h0, 9);
      do_irq(32'h0, 9);
      // R9 unarmed after reset: ticks raise no flag
      do_tick(0, 2);
      do_rd(8'h20, 32'h0, 9);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule